// File: doc/BRIEF.md
# Pulsed Program-and-Verify Controller

This block sits on the programmer side of a one-time-programmable memory and burns a contiguous range of words into it. For each address it drives the word onto the memory's data pins, fires a fixed-width active-low program strobe, releases the bus and reads the word back. On a match it steps to the next address. On a mismatch it fires another strobe, up to 25 strobes per word. While this per-word loop runs, two flags ask an external regulator for the raised programming and supply voltages.

Once the last address is done, the flags drop back to the normal level and every word in the range is read and compared again. The expected word for each address comes from a data source that sees the current address on `src_addr` and answers on `src_data` in the same cycle.

Every interval is a parameter counted in clock cycles, with defaults derived from a cycles-per-microsecond parameter. These intervals are the setup before a strobe, the strobe width, the data hold after it and the read-back settle time. A failure latches the address and the phase it failed in. The done state is then held until the failure is acknowledged.

Top module: `otp_prog_ctrl`

## Requirements
- R1: A start pulse taken while idle, or while done after a pass, loads the first address, clears the per-word strobe count, raises both voltage-request flags and the chip enable, and sets `busy`.
- R2: Each program strobe (`mem_pgm_n` low) lasts exactly `PULSE_CYC` cycles. For its whole duration output enable is inactive, chip enable is active, the data bus is driven and both voltage-request flags are high.
- R3: Before every strobe, address, write data, chip enable, data drive and an inactive output enable are held steady for at least `SETUP_CYC` cycles.
- R4: After every strobe, address and write data stay driven and unchanged for at least `HOLD_CYC` cycles before the bus is released.
- R5: A read-back holds output enable low with the program strobe high and the data bus released. Read data is sampled after output enable has been low for `OE_CYC` cycles.
- R6: After a read-back that matches, the controller moves to the next address. After one that does not match, it fires another strobe at the same address. A word that needs k strobes (k ≤ 25) gets exactly k.
- R7: If a word still mismatches after its 25th strobe, the controller stops with `done`=1, `fail`=1, `pass`=0, `fail_addr` set to that address and `fail_phase`=0.
- R8: After the last address is programmed, both voltage-request flags go low. The controller then waits `SETUP_CYC` cycles and re-reads every word from the first address up. The first mismatch stops it with `fail`=1, `fail_phase`=1 and `fail_addr` set to that address.
- R9: If every word matches in the final pass, the controller stops with `done`=1, `pass`=1, `fail`=0.
- R10: While a failure is latched, `start` is ignored (done stays set and no memory cycle begins). A `fail_ack` pulse returns the controller to idle with `done` and `fail` cleared.
- R11: After reset, chip enable, output enable and program strobe are inactive (high), both voltage-request flags are low, and `busy`, `done`, `pass` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin programming the range |
| fail_ack | input | 1 | Clear a latched result and return to idle |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range (inclusive) |
| src_addr | output | AW | Address presented to the data source |
| src_data | input | DW | Expected word for `src_addr` |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Word driven to the memory while programming |
| mem_wdrive | output | 1 | High while `mem_wdata` should drive the data pins |
| mem_rdata | input | DW | Word read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_raise | output | 1 | Request raised programming voltage |
| vcc_raise | output | 1 | Request raised supply voltage |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Run finished with every word verified |
| fail | output | 1 | Run finished with a failure |
| fail_addr | output | AW | Address that failed |
| fail_phase | output | 1 | 0 = per-word loop, 1 = final pass |

## Verification
The strobe count per address shows up directly in the number of `mem_pgm_n` falls per run. A retry counter that is wrong by one therefore changes the total, or turns a 25-strobe word from pass into fail, by the end of that run. A timer loaded with the wrong value shows up on the very next strobe or read as a wrong width, setup or hold count. A phase or address register that is wrong is caught at `done`, where the latched `fail_addr` and `fail_phase` are compared with values worked out from each word's required strobe count and from a cell that reads wrong only at normal supply.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RBACK,
        ST_FVSET,
        ST_FVREAD,
        ST_DONE
    } prog_state_e;

    typedef enum logic {
        PH_WORD  = 1'b0,
        PH_FINAL = 1'b1
    } fail_phase_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_us);
        return (ns * per_us + 999) / 1000;
    endfunction

endpackage

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (load)        remain <= load_val;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/otp_prog_pcnt.sv
module otp_prog_pcnt #(
    parameter int unsigned MAXP = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_max
);
    localparam int unsigned CW = $clog2(MAXP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_max = (cnt == CW'(MAXP));

    // R7: the controller never fires a strobe past the limit
    p_pulse_cap_r7: assert property (@(posedge clk) disable iff (rst)
        at_max |-> !inc)
        else $error("pulse count would exceed limit");

endmodule

// File: rtl/otp_prog_addr.sv
module otp_prog_addr #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          inc,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= first;
        else if (inc)  addr <= addr + 1'b1;
    end

    assign at_last = (addr == last);

    // R6: the sequencer only steps while inside the range
    p_step_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        inc |-> !at_last)
        else $error("address stepped past the last location");

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_prog_pkg::*;
#(
    parameter int unsigned AW           = 16,
    parameter int unsigned DW           = 16,
    parameter int unsigned TICKS_PER_US = 125,
    parameter int unsigned SETUP_CYC    = 2 * TICKS_PER_US,
    parameter int unsigned PULSE_CYC    = 100 * TICKS_PER_US,
    parameter int unsigned HOLD_CYC     = 2 * TICKS_PER_US,
    parameter int unsigned OE_CYC       = ns_to_cyc(150, TICKS_PER_US),
    parameter int unsigned MAX_PULSES   = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          fail_ack,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wdrive,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_pgm_n,
    output logic          vpp_raise,
    output logic          vcc_raise,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          fail_phase
);
    localparam int unsigned LONGEST = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, OE_CYC);
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] LD_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] LD_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_HOLD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LD_OE    = TW'(OE_CYC - 1);

    prog_state_e   state, state_d;
    fail_phase_e   ph_q, ph_d;
    logic          pass_q, fail_q;
    logic [AW-1:0] faddr_q;

    logic          t_load, t_exp;
    logic [TW-1:0] t_val;
    logic          a_load, a_inc, a_last;
    logic [AW-1:0] addr;
    logic          p_clr, p_inc, p_max;
    logic          set_pass, set_fail, clr_res;
    logic          word_ok;

    otp_prog_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    otp_prog_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .load(a_load), .inc(a_inc),
        .first(first_addr), .last(last_addr), .addr(addr), .at_last(a_last)
    );

    otp_prog_pcnt #(.MAXP(MAX_PULSES)) u_pcnt (
        .clk(clk), .rst(rst), .clr(p_clr), .inc(p_inc), .at_max(p_max)
    );

    assign word_ok = (mem_rdata == src_data);

    always_comb begin
        state_d  = state;
        t_load   = 1'b0;
        t_val    = '0;
        a_load   = 1'b0;
        a_inc    = 1'b0;
        p_clr    = 1'b0;
        p_inc    = 1'b0;
        set_pass = 1'b0;
        set_fail = 1'b0;
        clr_res  = 1'b0;
        ph_d     = PH_WORD;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (state == ST_DONE && fail_ack) begin
                    state_d = ST_IDLE;
                    clr_res = 1'b1;
                end else if (start && !fail_q) begin
                    state_d = ST_SETUP;
                    t_load  = 1'b1;
                    t_val   = LD_SETUP;
                    a_load  = 1'b1;
                    p_clr   = 1'b1;
                    clr_res = 1'b1;
                end
            end
            ST_SETUP: if (t_exp) begin
                state_d = ST_PULSE;
                t_load  = 1'b1;
                t_val   = LD_PULSE;
                p_inc   = 1'b1;
            end
            ST_PULSE: if (t_exp) begin
                state_d = ST_HOLD;
                t_load  = 1'b1;
                t_val   = LD_HOLD;
            end
            ST_HOLD: if (t_exp) begin
                state_d = ST_RBACK;
                t_load  = 1'b1;
                t_val   = LD_OE;
            end
            ST_RBACK: if (t_exp) begin
                t_load = 1'b1;
                t_val  = LD_SETUP;
                if (word_ok) begin
                    if (a_last) begin
                        state_d = ST_FVSET;
                        a_load  = 1'b1;
                    end else begin
                        state_d = ST_SETUP;
                        a_inc   = 1'b1;
                        p_clr   = 1'b1;
                    end
                end else if (p_max) begin
                    state_d  = ST_DONE;
                    set_fail = 1'b1;
                    ph_d     = PH_WORD;
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_FVSET: if (t_exp) begin
                state_d = ST_FVREAD;
                t_load  = 1'b1;
                t_val   = LD_OE;
            end
            ST_FVREAD: if (t_exp) begin
                if (!word_ok) begin
                    state_d  = ST_DONE;
                    set_fail = 1'b1;
                    ph_d     = PH_FINAL;
                end else if (a_last) begin
                    state_d  = ST_DONE;
                    set_pass = 1'b1;
                end else begin
                    a_inc  = 1'b1;
                    t_load = 1'b1;
                    t_val  = LD_OE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            faddr_q <= '0;
            ph_q    <= PH_WORD;
        end else begin
            state <= state_d;
            if (clr_res) begin
                pass_q  <= 1'b0;
                fail_q  <= 1'b0;
                faddr_q <= '0;
                ph_q    <= PH_WORD;
            end
            if (set_fail) begin
                fail_q  <= 1'b1;
                faddr_q <= addr;
                ph_q    <= ph_d;
            end
            if (set_pass) pass_q <= 1'b1;
        end
    end

    logic loop_phase;
    assign loop_phase = (state == ST_SETUP) || (state == ST_PULSE) ||
                        (state == ST_HOLD)  || (state == ST_RBACK);

    assign busy       = (state != ST_IDLE) && (state != ST_DONE);
    assign done       = (state == ST_DONE);
    assign pass       = pass_q;
    assign fail       = fail_q;
    assign fail_addr  = faddr_q;
    assign fail_phase = ph_q;
    assign src_addr   = addr;
    assign mem_addr   = addr;
    assign mem_wdata  = src_data;
    assign mem_wdrive = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
    assign mem_ce_n   = !busy;
    assign mem_oe_n   = !((state == ST_RBACK) || (state == ST_FVREAD));
    assign mem_pgm_n  = (state != ST_PULSE);
    assign vpp_raise  = loop_phase;
    assign vcc_raise  = loop_phase;

    // R2: strobe only with raised voltages, device selected, outputs off, bus driven
    p_strobe_cond_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_pgm_n |-> (vpp_raise && vcc_raise && mem_oe_n && !mem_ce_n && mem_wdrive))
        else $error("strobe under wrong conditions");

    // R3: address does not move during a strobe
    p_strobe_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_pgm_n && !$past(mem_pgm_n)) |-> $stable(mem_addr))
        else $error("address moved during strobe");

    // R5: reading never overlaps a strobe or a driven bus
    p_read_cond_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_pgm_n && !mem_wdrive))
        else $error("read overlaps write");

    // R8: no strobe once the voltages have been dropped during a run
    p_final_nostrobe_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !vcc_raise) |-> mem_pgm_n)
        else $error("strobe at normal supply");

    // R9: a finished run reports exactly one outcome
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass != fail))
        else $error("ambiguous outcome");

    // R10: a latched failure survives until acknowledged
    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (fail && !fail_ack) |=> fail)
        else $error("failure dropped without acknowledge");

endmodule

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb;
    localparam int AW = 4, DW = 16;
    localparam int SET = 3, PUL = 6, HLD = 2, OEC = 2, MAXP = 25;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, start, fail_ack;
    logic [AW-1:0] first_addr, last_addr, src_addr, mem_addr, fail_addr;
    logic [DW-1:0] src_data, mem_wdata, mem_rdata;
    logic mem_wdrive, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_raise, vcc_raise;
    logic busy, done, pass, fail, fail_phase;

    otp_prog_ctrl #(.AW(AW), .DW(DW), .SETUP_CYC(SET), .PULSE_CYC(PUL),
                    .HOLD_CYC(HLD), .OE_CYC(OEC), .MAX_PULSES(MAXP)) u_dut (
        .clk(clk), .rst(rst), .start(start), .fail_ack(fail_ack),
        .first_addr(first_addr), .last_addr(last_addr),
        .src_addr(src_addr), .src_data(src_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdrive(mem_wdrive),
        .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_pgm_n(mem_pgm_n), .vpp_raise(vpp_raise), .vcc_raise(vcc_raise),
        .busy(busy), .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_phase(fail_phase)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gold(input logic [AW-1:0] a);
        return 16'h1230 + {8'h00, 4'h0, a} * 16'h0101;
    endfunction

    // memory model: word needs need[a] strobes; weak cell misreads at normal supply
    int            need [16];
    logic [DW-1:0] cells [16];
    int            strobes [16];
    bit            weak_en;
    logic [AW-1:0] weak_a;

    assign src_data = gold(src_addr);
    assign mem_rdata = (!mem_ce_n && !mem_oe_n) ?
        (cells[mem_addr] ^ ((weak_en && mem_addr == weak_a && !vcc_raise) ? 16'h0001 : 16'h0000))
        : 16'h0000;

    typedef struct { bit ok; bit ph; int faddr; int pulses; } exp_t;
    exp_t sb_q[$];

    // monitor and memory model
    logic prev_pgm = 1'b1, prev_oe = 1'b1, prev_drive = 1'b0, prev_done = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_wdata = '0;
    int wlen = 0, setup_cnt = 0, hold_cnt = 0, pulse_seen = 0;
    bit after_pulse = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_pgm && !mem_pgm_n) begin
                pulse_seen++;
                chk(setup_cnt >= SET, "R3 setup cycles", setup_cnt, SET);
                wlen = 0;
            end
            if (!mem_pgm_n) wlen++;
            if (!prev_pgm && mem_pgm_n) begin
                chk(wlen == PUL, "R2 strobe width", wlen, PUL);
                if (vpp_raise) begin
                    strobes[prev_addr]++;
                    if (strobes[prev_addr] >= need[prev_addr])
                        cells[prev_addr] = cells[prev_addr] & prev_wdata;
                end
                after_pulse = 1;
                hold_cnt = 0;
            end
            if (mem_wdrive && !mem_ce_n && mem_oe_n && mem_pgm_n) begin
                if (prev_drive && prev_pgm && mem_addr == prev_addr && mem_wdata == prev_wdata)
                    setup_cnt++;
                else
                    setup_cnt = 1;
            end else setup_cnt = 0;
            if (after_pulse && mem_wdrive && mem_pgm_n &&
                mem_addr == prev_addr && mem_wdata == prev_wdata)
                hold_cnt++;
            if (after_pulse && prev_drive && !mem_wdrive) begin
                chk(hold_cnt >= HLD, "R4 hold cycles", hold_cnt, HLD);
                after_pulse = 0;
            end
            if (prev_oe && !mem_oe_n)
                chk(mem_pgm_n && !mem_wdrive, "R5 read conditions",
                    {mem_pgm_n, mem_wdrive}, 2);
            if (done && !prev_done) begin
                exp_t e;
                if (sb_q.size() == 0) chk(0, "scoreboard underflow", 0, 1);
                else begin
                    e = sb_q.pop_front();
                    chk(pass == e.ok, "R9 pass flag", pass, e.ok);
                    chk(fail == !e.ok, "R7 fail flag", fail, !e.ok);
                    if (!e.ok) begin
                        chk(fail_addr == e.faddr, e.ph ? "R8 fail address" : "R7 fail address",
                            fail_addr, e.faddr);
                        chk(fail_phase == e.ph, e.ph ? "R8 phase" : "R7 phase",
                            fail_phase, e.ph);
                    end
                    chk(pulse_seen == e.pulses, "R6 strobe total", pulse_seen, e.pulses);
                end
            end
        end
        prev_pgm   = mem_pgm_n;
        prev_oe    = mem_oe_n;
        prev_drive = mem_wdrive;
        prev_done  = done;
        prev_addr  = mem_addr;
        prev_wdata = mem_wdata;
    end

    task automatic run(input int f, input int l, input bit we, input int wa);
        exp_t e;
        e.ok = 1; e.ph = 0; e.faddr = 0; e.pulses = 0;
        for (int a = f; a <= l; a++) begin
            if (need[a] > MAXP) begin
                e.pulses += MAXP; e.ok = 0; e.ph = 0; e.faddr = a;
                break;
            end
            e.pulses += need[a];
        end
        if (e.ok && we && wa >= f && wa <= l) begin
            e.ok = 0; e.ph = 1; e.faddr = wa;
        end
        sb_q.push_back(e);
        for (int a = 0; a < 16; a++) begin cells[a] = '1; strobes[a] = 0; end
        weak_en = we; weak_a = AW'(wa);
        pulse_seen = 0;
        first_addr = AW'(f); last_addr = AW'(l);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && vpp_raise && vcc_raise && !mem_ce_n, "R1 run entry",
            {busy, vpp_raise, vcc_raise, mem_ce_n}, 4'b1110);
        chk(mem_addr == AW'(f), "R1 first address", mem_addr, f);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        wait (cyc == LIMIT);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; fail_ack = 1'b0;
        first_addr = '0; last_addr = '0; weak_en = 0; weak_a = '0;
        for (int a = 0; a < 16; a++) begin need[a] = 1; cells[a] = '1; strobes[a] = 0; end
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R11 strobes idle",
            {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);
        chk(!vpp_raise && !vcc_raise, "R11 voltage flags", {vpp_raise, vcc_raise}, 0);
        chk(!busy && !done && !pass && !fail, "R11 status",
            {busy, done, pass, fail}, 0);
        rst = 1'b0;
        @(negedge clk);

        // every word takes one strobe
        run(0, 15, 0, 0);

        // mixed strobe counts with one word at exactly the limit
        for (int a = 0; a < 16; a++) need[a] = (a % 4) + 1;
        need[5] = 25;
        run(2, 9, 0, 0);

        // word that never programs: per-word failure
        for (int a = 0; a < 16; a++) need[a] = 1;
        need[3] = 26;
        run(0, 7, 0, 0);

        // R10: start ignored while a failure is latched
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        chk(done && !busy && fail && mem_ce_n, "R10 start ignored",
            {done, busy, fail, mem_ce_n}, 4'b1011);
        @(negedge clk) fail_ack = 1'b1;
        @(negedge clk) fail_ack = 1'b0;
        chk(!done && !fail && !busy, "R10 acknowledge", {done, fail, busy}, 0);

        // weak cell: passes at raised supply, fails the final pass
        need[3] = 1;
        run(4, 12, 1, 10);
        @(negedge clk) fail_ack = 1'b1;
        @(negedge clk) fail_ack = 1'b0;

        // single-word range needing three strobes
        need[6] = 3;
        run(6, 6, 0, 0);

        // restart straight from a passing done
        need[6] = 1;
        run(0, 2, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule